// File: doc/BRIEF.md
# Ident-Aligned 10 MHz Reference Divider

This block divides a 200 MHz reference clock by 20 to produce a 10 MHz square wave. A 100 kHz ident pulse train from the same source sets the divider's phase, so the square wave keeps a fixed and known phase relation both to the fast clock and to the ident pulse. The square wave is meant to drive the external frequency input of a network timing master. Its phase must therefore never move on its own once it is running.

The ident input is first brought into the clock domain through a synchronizer, and only its rising edge is used. The first rising edge after reset starts the divider with its count at zero. Every later edge is checked against the divider. An edge that arrives where a new output period begins counts as correct. An edge anywhere else raises a sticky misalignment flag, and the divider does not move. A separate sticky flag reports when ident edges stop arriving. Lock is reported after a run of correct edges. The divider is moved to a new phase only when the realign input is pulsed, and the move happens at the next ident edge.

Top module: `ident_clk_divider`

## Requirements
- R1: While reset is high, and on the first clock edge after it, ref_o, lock_o, misalign_o and missing_o are all 0.
- R2: ref_o stays 0 until the first ident rising edge after reset. If ident_i is first sampled high at clock edge k, ref_o is 1 after edge k+2. That edge is count zero, and the synchronizer adds a fixed latency of two cycles.
- R3: Once started, ref_o has a period of 20 clocks. It is high on counts 0 to 9 and low on counts 10 to 19, with no gaps.
- R4: An ident edge that lands on count zero (a whole multiple of 20 clocks after the alignment edge) is correct. lock_o goes to 1 on the 4th consecutive correct edge after the alignment edge. A misplaced edge drops lock_o at once and restarts the run.
- R5: A misplaced ident edge sets misalign_o, which stays set until a realignment. The edge does not shift the phase of ref_o.
- R6: If no ident rising edge is acted on for 2020 clocks after the last one, missing_o is set and stays set, and lock_o is cleared. At 2019 clocks missing_o is still 0.
- R7: A one-cycle pulse on realign_i leaves the flags and the phase unchanged until the next ident edge. At that edge the divider restarts at count zero as in R2, and misalign_o, missing_o and lock_o are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 200 MHz reference clock |
| rst | input | 1 | Synchronous reset, active high |
| ident_i | input | 1 | 100 kHz ident pulse, asynchronous to clk |
| realign_i | input | 1 | Request to re-phase the divider at the next ident edge |
| ref_o | output | 1 | 10 MHz square-wave reference, registered |
| lock_o | output | 1 | Run of correctly placed ident edges reached |
| misalign_o | output | 1 | Sticky: an ident edge missed count zero |
| missing_o | output | 1 | Sticky: ident edges stopped arriving |

## Verification
If the divide count were off, or if it moved when it should not, ref_o would show it within one 20-clock period: a high phase would have the wrong length, or an edge would sit in the wrong cycle relative to the alignment edge. Mistakes in the edge checks appear at the flags, in the cycle after the ident edge has passed through the synchronizer. A wrong timeout count appears at missing_o, where the test samples both 2019 and 2020 clocks after the last edge. A lock counter that saturates or resets wrongly shows as lock_o rising on the wrong edge of a four-edge run.

// File: rtl/ident_div_pkg.sv
package ident_div_pkg;

    localparam int DIV_RATIO_DEF   = 20;
    localparam int IDENT_DIVS_DEF  = 100;
    localparam int LOCK_EDGES_DEF  = 4;
    localparam int SYNC_STAGES_DEF = 2;

    typedef enum logic [1:0] {
        EDGE_NONE,
        EDGE_LOAD,
        EDGE_GOOD,
        EDGE_BAD
    } edge_kind_e;

    typedef struct packed {
        logic aligned;
        logic locked;
        logic misaligned;
        logic missing;
    } div_status_t;

    function automatic edge_kind_e classify_edge(
        input logic rise,
        input logic aligned,
        input logic pending,
        input logic at_wrap
    );
        if (!rise)                 return EDGE_NONE;
        if (!aligned || pending)   return EDGE_LOAD;
        if (at_wrap)               return EDGE_GOOD;
        return EDGE_BAD;
    endfunction

endpackage

// File: rtl/ident_sync_edge.sv
module ident_sync_edge #(
    parameter int STAGES = ident_div_pkg::SYNC_STAGES_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic rise_o
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_i};
            prev_q <= sync_q[STAGES-1];
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/div_phase_counter.sv
module div_phase_counter #(
    parameter int DIV_RATIO = ident_div_pkg::DIV_RATIO_DEF,
    localparam int CNT_W    = $clog2(DIV_RATIO),
    localparam int HALF     = DIV_RATIO / 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o,
    output logic             ref_o
);
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(DIV_RATIO - 1);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_next;
    logic             ref_q;

    assign wrap_o   = (cnt_q == LAST_C);
    assign cnt_next = wrap_o ? '0 : cnt_q + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            ref_q <= 1'b0;
        end else if (load) begin
            cnt_q <= '0;
            ref_q <= 1'b1;
        end else if (run) begin
            cnt_q <= cnt_next;
            ref_q <= (cnt_next < HALF_C);
        end
    end

    assign cnt_o = cnt_q;
    assign ref_o = ref_q;
endmodule

// File: rtl/ident_lock_monitor.sv
module ident_lock_monitor
    import ident_div_pkg::*;
#(
    parameter int DIV_RATIO  = DIV_RATIO_DEF,
    parameter int IDENT_DIVS = IDENT_DIVS_DEF,
    parameter int LOCK_EDGES = LOCK_EDGES_DEF,
    localparam int TIMEOUT   = DIV_RATIO * IDENT_DIVS + DIV_RATIO,
    localparam int WATCH_W   = $clog2(TIMEOUT + 1),
    localparam int GOOD_W    = $clog2(LOCK_EDGES + 1)
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rise,
    input  logic        at_wrap,
    input  logic        realign_req,
    output logic        load_o,
    output div_status_t status_o
);
    localparam logic [WATCH_W-1:0] WATCH_MAX = WATCH_W'(TIMEOUT - 1);
    localparam logic [GOOD_W-1:0]  GOOD_MAX  = GOOD_W'(LOCK_EDGES);
    localparam logic [GOOD_W-1:0]  GOOD_LAST = GOOD_W'(LOCK_EDGES - 1);

    div_status_t        st_q;
    logic               pend_q;
    logic [WATCH_W-1:0] watch_q;
    logic [GOOD_W-1:0]  good_q;
    edge_kind_e         kind;

    assign kind   = classify_edge(rise, st_q.aligned, pend_q, at_wrap);
    assign load_o = (kind == EDGE_LOAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            pend_q  <= 1'b0;
            watch_q <= '0;
            good_q  <= '0;
        end else begin
            if (realign_req && st_q.aligned) pend_q <= 1'b1;
            unique case (kind)
                EDGE_LOAD: begin
                    st_q.aligned    <= 1'b1;
                    st_q.locked     <= 1'b0;
                    st_q.misaligned <= 1'b0;
                    st_q.missing    <= 1'b0;
                    pend_q          <= 1'b0;
                    watch_q         <= '0;
                    good_q          <= '0;
                end
                EDGE_GOOD: begin
                    watch_q <= '0;
                    if (good_q < GOOD_MAX)   good_q      <= good_q + 1'b1;
                    if (good_q >= GOOD_LAST) st_q.locked <= 1'b1;
                end
                EDGE_BAD: begin
                    watch_q         <= '0;
                    good_q          <= '0;
                    st_q.locked     <= 1'b0;
                    st_q.misaligned <= 1'b1;
                end
                default: begin
                    if (st_q.aligned) begin
                        if (watch_q == WATCH_MAX) begin
                            st_q.missing <= 1'b1;
                            st_q.locked  <= 1'b0;
                            good_q       <= '0;
                        end else begin
                            watch_q <= watch_q + 1'b1;
                        end
                    end
                end
            endcase
        end
    end

    assign status_o = st_q;
endmodule

// File: rtl/ident_clk_divider.sv
module ident_clk_divider
    import ident_div_pkg::*;
#(
    parameter int DIV_RATIO   = DIV_RATIO_DEF,
    parameter int IDENT_DIVS  = IDENT_DIVS_DEF,
    parameter int LOCK_EDGES  = LOCK_EDGES_DEF,
    parameter int SYNC_STAGES = SYNC_STAGES_DEF,
    localparam int CNT_W      = $clog2(DIV_RATIO)
) (
    input  logic clk,
    input  logic rst,
    input  logic ident_i,
    input  logic realign_i,
    output logic ref_o,
    output logic lock_o,
    output logic misalign_o,
    output logic missing_o
);
    logic             ident_rise;
    logic             edge_load;
    logic             at_wrap;
    logic             aligned;
    logic [CNT_W-1:0] phase_cnt;
    div_status_t      status;

    ident_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ident_i),
        .rise_o  (ident_rise)
    );

    ident_lock_monitor #(
        .DIV_RATIO  (DIV_RATIO),
        .IDENT_DIVS (IDENT_DIVS),
        .LOCK_EDGES (LOCK_EDGES)
    ) u_mon (
        .clk         (clk),
        .rst         (rst),
        .rise        (ident_rise),
        .at_wrap     (at_wrap),
        .realign_req (realign_i),
        .load_o      (edge_load),
        .status_o    (status)
    );

    assign aligned = status.aligned;

    div_phase_counter #(.DIV_RATIO(DIV_RATIO)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .run    (aligned),
        .load   (edge_load),
        .cnt_o  (phase_cnt),
        .wrap_o (at_wrap),
        .ref_o  (ref_o)
    );

    assign lock_o     = status.locked;
    assign misalign_o = status.misaligned;
    assign missing_o  = status.missing;
endmodule

// File: rtl/ident_clk_divider_chk.sv
module ident_clk_divider_chk #(
    parameter int DIV_RATIO = 20,
    localparam int CNT_W    = $clog2(DIV_RATIO),
    localparam int HALF     = DIV_RATIO / 2
) (
    input logic             clk,
    input logic             rst,
    input logic             ref_o,
    input logic             lock_o,
    input logic             misalign_o,
    input logic             missing_o,
    input logic [CNT_W-1:0] cnt,
    input logic             aligned,
    input logic             load
);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!ref_o && !lock_o && !misalign_o && !missing_o)); // R1
    AST_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !aligned |-> !ref_o); // R2
    AST_LOAD_ALIGNS: assert property (@(posedge clk) disable iff (rst)
        load |=> (ref_o && cnt == '0)); // R2
    AST_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        $rose(ref_o) |-> cnt == '0); // R3
    AST_FALL_AT_HALF: assert property (@(posedge clk) disable iff (rst)
        $fell(ref_o) |-> cnt == HALF_C); // R3
    AST_LOCK_NEEDS_ALIGN: assert property (@(posedge clk) disable iff (rst)
        lock_o |-> aligned); // R4
    AST_MISALIGN_STICKY: assert property (@(posedge clk) disable iff (rst)
        (misalign_o && !load) |=> misalign_o); // R5
    AST_MISSING_STICKY: assert property (@(posedge clk) disable iff (rst)
        (missing_o && !load) |=> missing_o); // R6
endmodule

bind ident_clk_divider ident_clk_divider_chk #(.DIV_RATIO(DIV_RATIO)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ref_o      (ref_o),
    .lock_o     (lock_o),
    .misalign_o (misalign_o),
    .missing_o  (missing_o),
    .cnt        (phase_cnt),
    .aligned    (aligned),
    .load       (edge_load)
);

// File: tb/test_ident_clk_divider.sv
`timescale 1ns/1ps
module test_ident_clk_divider;
    localparam realtime CLK_PERIOD = 5.0;
    localparam int DIV     = 20;
    localparam int PERIOD  = 2000;
    localparam int TIMEOUT = PERIOD + DIV;

    typedef struct packed {
        int unsigned gap;
        logic        exp_lock;
        logic        exp_mis;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t VECS [NV] = '{
        '{50,   1'b0, 1'b0},
        '{2000, 1'b0, 1'b0},
        '{2000, 1'b0, 1'b0},
        '{2000, 1'b0, 1'b0},
        '{2000, 1'b1, 1'b0},
        '{2000, 1'b1, 1'b0},
        '{2012, 1'b0, 1'b1},
        '{1988, 1'b0, 1'b1},
        '{2000, 1'b0, 1'b1},
        '{2000, 1'b0, 1'b1},
        '{2000, 1'b1, 1'b1}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ident_i = 1'b0;
    logic realign_i = 1'b0;
    logic ref_o, lock_o, misalign_o, missing_o;

    int n_tests = 0;
    int n_fail  = 0;
    int elapsed = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ident_clk_divider i_ident_clk_divider (
        .clk(clk), .rst(rst), .ident_i(ident_i), .realign_i(realign_i),
        .ref_o(ref_o), .lock_o(lock_o), .misalign_o(misalign_o), .missing_o(missing_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
        end
    endtask

    // drive an ident edge after gap negedges; return just after the edge it takes effect
    task automatic send_edge(input int gap);
        repeat (gap) @(negedge clk);
        ident_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
    endtask

    task automatic end_edge();
        @(negedge clk);
        ident_i = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (5) @(posedge clk);
        #1;
        chk("R1", "ref in reset", ref_o, 1'b0);
        chk("R1", "lock in reset", lock_o, 1'b0);
        chk("R1", "misalign in reset", misalign_o, 1'b0);
        chk("R1", "missing in reset", missing_o, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        repeat (20) @(posedge clk);
        #1;
        chk("R2", "ref idle before first ident", ref_o, 1'b0);

        // table walk: R2 alignment, R4 lock, R5 misalignment without phase jump
        for (int i = 0; i < NV; i++) begin
            send_edge(i == 0 ? int'(VECS[i].gap) : int'(VECS[i].gap) - 3);
            if (i > 0) elapsed += int'(VECS[i].gap);
            chk(i == 0 ? "R2" : "R5", "ref phase at ident", ref_o, (elapsed % DIV) < DIV / 2);
            chk("R4", "lock after ident", lock_o, VECS[i].exp_lock);
            chk("R5", "misalign after ident", misalign_o, VECS[i].exp_mis);
            end_edge();
        end

        // R6: timeout boundary
        repeat (TIMEOUT - 1) @(posedge clk);
        #1;
        chk("R6", "missing one clock early", missing_o, 1'b0);
        chk("R6", "lock one clock early", lock_o, 1'b1);
        @(posedge clk);
        #1;
        chk("R6", "missing at timeout", missing_o, 1'b1);
        chk("R6", "lock at timeout", lock_o, 1'b0);

        // R7: realign request waits for an ident edge
        @(negedge clk);
        realign_i = 1'b1;
        @(negedge clk);
        realign_i = 1'b0;
        repeat (10) @(posedge clk);
        #1;
        chk("R7", "misalign held before edge", misalign_o, 1'b1);
        chk("R7", "missing held before edge", missing_o, 1'b1);
        send_edge(333);
        chk("R7", "ref restarts high", ref_o, 1'b1);
        chk("R7", "misalign cleared", misalign_o, 1'b0);
        chk("R7", "missing cleared", missing_o, 1'b0);
        chk("R7", "lock cleared", lock_o, 1'b0);
        // R3: duty cycle over two periods
        for (int j = 1; j < 2 * DIV; j++) begin
            @(posedge clk);
            #1;
            chk("R3", "ref duty", ref_o, (j % DIV) < DIV / 2);
        end
        end_edge();
        for (int k = 0; k < 4; k++) begin
            send_edge(k == 0 ? PERIOD - 42 : PERIOD - 3);
            chk("R4", "relock ref phase", ref_o, 1'b1);
            chk("R4", "relock lock", lock_o, k == 3);
            chk("R5", "relock misalign", misalign_o, 1'b0);
            end_edge();
        end

        // R1: mid-run reset
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "ref after reset", ref_o, 1'b0);
        chk("R1", "lock after reset", lock_o, 1'b0);
        chk("R1", "misalign after reset", misalign_o, 1'b0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule